// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block sits beside a DDR-style SDRAM command bus and watches it at every rising clock edge. It decodes the clock-enable, chip-select and the three command strobes into one command. It follows the state of every bank: whether a row is open, whether an auto-precharge burst is running, and whether a bank is still recovering from the precharge that such a burst ends with. When a command breaks a sequencing rule, it raises a one-cycle violation pulse and gives a code that names the rule.

The monitor only observes. An illegal command is reported and then left out of the tracked state, so a single mistake on the bus does not turn into a chain of further reports. There is no data stream here. The command bus is sampled without a handshake and every output is a plain registered level, so valid/ready and back-pressure do not apply. The burst length, the precharge recovery time and the quiet gap after a mode-register write are parameters. Their defaults are 4 beats (2 clock cycles of burst), 3 cycles and 2 cycles.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With the previous and current `cke` high, the strobes `{cs_n,ras_n,cas_n,we_n}` decode as follows, and `cmd_o` shows the code one cycle after the sampling edge. 1xxx is deselect (0). 0111 is no-op (1). 0011 is activate (2). 0101 is read (3). 0100 is write (4). 0010 is precharge (5). 0110 is burst stop (6). 0001 is refresh (7). 0000 is mode-register write (9).
- R2: The bank index is the bank-address input with its bits reversed. `ba`=00 gives bank 0, 10 gives bank 1, 01 gives bank 2 and 11 gives bank 3. `bank_o` shows it one cycle after the sampling edge, and bit i of `bank_open_o` belongs to bank i.
- R3: A legal activate opens the row of the selected bank. An activate to a bank that already has an open row raises code 5.
- R4: A precharge with `a10` high closes every bank. With `a10` low it closes only the selected bank.
- R5: A read or write to a bank with no open row raises code 4.
- R6: A read or write with `a10` high starts an auto-precharge burst, and `ap_busy_o` stays high for BURST_LEN/2 cycles. Any read or write inside that window raises code 3. When the burst ends, its bank closes, and reads and writes to other open banks are legal again.
- R7: A burst stop ends a running auto-precharge burst at once and closes its bank. A burst stop with no burst running is legal and changes nothing.
- R8: An activate to a bank in the T_RP cycles that follow the end of its auto-precharge burst raises code 6. The activate is legal in the cycle after that.
- R9: A mode-register write, a refresh or a self-refresh entry raises code 1 while any bank is open or recovering.
- R10: In the MRS_GAP cycles that follow a legal mode-register write, any command other than no-op or deselect raises code 2.
- R11: `viol_o` is high for exactly one cycle for each illegal command, and `viol_code_o` is 0 when `viol_o` is low. An illegal command does not change any bank's state.
- R12: The refresh encoding with `cke` falling (high at the previous edge, low now) decodes as self-refresh entry (8). Any other command with `cke` low, or any command at an edge where the previous `cke` was low, decodes as no-op (1).
- R13: While `rst_n` is low, `cmd_o` is 0, no bank is open, `ap_busy_o` is 0 and `viol_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable from the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BANK_BITS | Bank address |
| a10 | input | 1 | All-bank / auto-precharge address bit |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BANK_BITS | Selected bank index |
| bank_open_o | output | 2**BANK_BITS | Open-row flag per bank |
| ap_busy_o | output | 1 | Auto-precharge burst running |
| viol_o | output | 1 | Violation pulse |
| viol_code_o | output | 3 | Rule broken: 1 not idle, 2 locked, 3 burst busy, 4 row closed, 5 row open, 6 recovering |

## Verification
Every result belongs to the command sampled at one rising edge and is due exactly one cycle later. This holds for the decoded command, the bank, the violation pulse and its code, and the bank and burst flags. The bench drives each command on a falling edge and compares all outputs at the following falling edge, after the register stage has settled. The windows that are counted in cycles are walked one command per cycle and checked on the cycles just inside and just outside their bounds: the burst window, the recovery window and the mode-register gap. With the defaults these bounds are 2, 3 and 2 cycles.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_BST   = 4'd6,
    CMD_REF   = 4'd7,
    CMD_SREF  = 4'd8,
    CMD_MRS   = 4'd9
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_NOT_IDLE   = 3'd1,
    ERR_LOCKED     = 3'd2,
    ERR_AP_BUSY    = 3'd3,
    ERR_ROW_CLOSED = 3'd4,
    ERR_ROW_OPEN   = 3'd5,
    ERR_RECOVERY   = 3'd6
  } err_e;
endpackage

// File: rtl/sdcg_decode.sv
module sdcg_decode
  import sdcg_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cke_prev) begin
      cmd = CMD_NOP;                       // R12: bus asleep last edge
    end else if (!cke) begin
      cmd = (!cs_n && {ras_n, cas_n, we_n} == 3'b001) ? CMD_SREF : CMD_NOP;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b010:  cmd = CMD_PRE;
        3'b011:  cmd = CMD_ACT;
        3'b100:  cmd = CMD_WR;
        3'b101:  cmd = CMD_RD;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcg_bank.sv
module sdcg_bank #(
  parameter int T_RP = 3,
  parameter int RW   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_req,
  input  logic pre_req,
  input  logic ap_done,
  output logic is_open,
  output logic recovering
);
  logic [RW-1:0] rec_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      rec_cnt <= '0;
    end else begin
      if (act_req)                is_open <= 1'b1;
      else if (pre_req || ap_done) is_open <= 1'b0;

      if (ap_done)              rec_cnt <= RW'(T_RP);
      else if (rec_cnt != '0)   rec_cnt <= rec_cnt - 1'b1;
    end
  end

  assign recovering = (rec_cnt != '0);
endmodule

// File: rtl/sdcg_rules.sv
module sdcg_rules
  import sdcg_pkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int NB = 1 << BANK_BITS
) (
  input  cmd_e                 cmd,
  input  logic [BANK_BITS-1:0] bank,
  input  logic                 locked,
  input  logic                 ap_busy,
  input  logic [NB-1:0]        row_open,
  input  logic [NB-1:0]        recov,
  output err_e                 err
);
  always_comb begin
    err = ERR_NONE;
    if (locked && cmd != CMD_NOP && cmd != CMD_DESEL) begin
      err = ERR_LOCKED;
    end else begin
      case (cmd)
        CMD_MRS, CMD_REF, CMD_SREF:
          if ((|row_open) || (|recov)) err = ERR_NOT_IDLE;
        CMD_ACT:
          if (row_open[bank])    err = ERR_ROW_OPEN;
          else if (recov[bank])  err = ERR_RECOVERY;
        CMD_RD, CMD_WR:
          if (ap_busy)              err = ERR_AP_BUSY;
          else if (!row_open[bank]) err = ERR_ROW_CLOSED;
        default: err = ERR_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdcg_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int MRS_GAP   = 2,
  localparam int NB = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_BITS-1:0] ba,
  input  logic                 a10,
  output logic [3:0]           cmd_o,
  output logic [BANK_BITS-1:0] bank_o,
  output logic [NB-1:0]        bank_open_o,
  output logic                 ap_busy_o,
  output logic                 viol_o,
  output logic [2:0]           viol_code_o
);
  localparam int BURST_CYC = (BURST_LEN / 2 < 1) ? 1 : BURST_LEN / 2;
  localparam int BW = $clog2(BURST_CYC + 1);
  localparam int LW = $clog2(MRS_GAP + 1);
  localparam int RW = $clog2(T_RP + 1);

  logic                 cke_q;
  cmd_e                 cmd;
  err_e                 err;
  logic                 legal;
  logic [BANK_BITS-1:0] bank_sel;
  logic [LW-1:0]        lock_cnt;
  logic [BW-1:0]        burst_cnt;
  logic [BANK_BITS-1:0] burst_bank;
  logic                 burst_end;
  logic [NB-1:0]        row_open, recov, act_req, pre_req, ap_done;

  // Bank index is the bank-address field read back to front.
  always_comb begin
    for (int i = 0; i < BANK_BITS; i++) bank_sel[i] = ba[BANK_BITS-1-i];
  end

  sdcg_decode u_dec (
    .cke_prev(cke_q), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  sdcg_rules #(.BANK_BITS(BANK_BITS)) u_rules (
    .cmd(cmd), .bank(bank_sel), .locked(lock_cnt != '0),
    .ap_busy(burst_cnt != '0), .row_open(row_open), .recov(recov), .err(err)
  );

  assign legal     = (err == ERR_NONE);
  assign burst_end = (burst_cnt != '0) &&
                     ((burst_cnt == BW'(1)) || (legal && cmd == CMD_BST));

  always_comb begin
    act_req = '0;
    pre_req = '0;
    ap_done = '0;
    if (legal && cmd == CMD_ACT) act_req[bank_sel] = 1'b1;
    if (legal && cmd == CMD_PRE) pre_req = a10 ? '1 : (NB'(1) << bank_sel);
    if (burst_end) ap_done[burst_bank] = 1'b1;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdcg_bank #(.T_RP(T_RP), .RW(RW)) u_bank (
      .clk(clk), .rst_n(rst_n), .act_req(act_req[b]), .pre_req(pre_req[b]),
      .ap_done(ap_done[b]), .is_open(row_open[b]), .recovering(recov[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q       <= 1'b1;
      lock_cnt    <= '0;
      burst_cnt   <= '0;
      burst_bank  <= '0;
      cmd_o       <= CMD_DESEL;
      bank_o      <= '0;
      viol_o      <= 1'b0;
      viol_code_o <= ERR_NONE;
    end else begin
      cke_q <= cke;

      if (legal && cmd == CMD_MRS) lock_cnt <= LW'(MRS_GAP);
      else if (lock_cnt != '0)     lock_cnt <= lock_cnt - 1'b1;

      if (legal && a10 && (cmd == CMD_RD || cmd == CMD_WR)) begin
        burst_cnt  <= BW'(BURST_CYC);
        burst_bank <= bank_sel;
      end else if (burst_end) begin
        burst_cnt <= '0;
      end else if (burst_cnt != '0) begin
        burst_cnt <= burst_cnt - 1'b1;
      end

      cmd_o       <= cmd;
      bank_o      <= bank_sel;
      viol_o      <= !legal;
      viol_code_o <= err;
    end
  end

  assign bank_open_o = row_open;
  assign ap_busy_o   = (burst_cnt != '0);
endmodule

// File: rtl/sdcg_chk.sv
module sdcg_chk
  import sdcg_pkg::*;
#(
  parameter int BANK_BITS = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [3:0]                  cmd_o,
  input logic [BANK_BITS-1:0]        bank_o,
  input logic [(1<<BANK_BITS)-1:0]   bank_open_o,
  input logic                        ap_busy_o,
  input logic                        viol_o,
  input logic [2:0]                  viol_code_o
);
  // R10
  lock_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o && viol_code_o == ERR_LOCKED) |->
      ($past(cmd_o, 1) == CMD_MRS || $past(cmd_o, 2) == CMD_MRS));

  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT && !viol_o) |-> bank_open_o[bank_o]);

  // R6
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ap_busy_o) |-> ((cmd_o == CMD_RD || cmd_o == CMD_WR) && !viol_o));

  // R9
  mrs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS && !viol_o) |-> (bank_open_o == '0 && !ap_busy_o));

  // R5
  closed_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o && viol_code_o == ERR_ROW_CLOSED) |-> !bank_open_o[bank_o]);

  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_BST && !viol_o && $past(ap_busy_o)) |-> !ap_busy_o);
endmodule

bind sdram_cmd_guard sdcg_chk #(.BANK_BITS(BANK_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_o(cmd_o), .bank_o(bank_o),
  .bank_open_o(bank_open_o), .ap_busy_o(ap_busy_o), .viol_o(viol_o),
  .viol_code_o(viol_code_o)
);

// File: tb/tb_sdram_cmd_guard.sv
module tb_sdram_cmd_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'b00;
  logic a10 = 1'b0;
  logic [3:0] cmd_o;
  logic [1:0] bank_o;
  logic [3:0] bank_open_o;
  logic ap_busy_o, viol_o;
  logic [2:0] viol_code_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sdram_cmd_guard dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o),
    .bank_o(bank_o), .bank_open_o(bank_open_o), .ap_busy_o(ap_busy_o),
    .viol_o(viol_o), .viol_code_o(viol_code_o)
  );

  // strobes {cs_n,ras_n,cas_n,we_n}
  localparam logic [3:0] S_NOP = 4'b0111, S_ACT = 4'b0011, S_RD = 4'b0101,
    S_WR = 4'b0100, S_PRE = 4'b0010, S_BST = 4'b0110, S_REF = 4'b0001,
    S_MRS = 4'b0000, S_DES = 4'b1111;

  // {strobes, ba, a10, exp cmd, exp code, exp open, exp busy}
  localparam int NV = 33;
  localparam logic [18:0] VEC [NV] = '{
    {S_MRS, 2'b00, 1'b0, 4'd9, 3'd0, 4'b0000, 1'b0},
    {S_ACT, 2'b00, 1'b0, 4'd2, 3'd2, 4'b0000, 1'b0},
    {S_NOP, 2'b00, 1'b0, 4'd1, 3'd0, 4'b0000, 1'b0},
    {S_ACT, 2'b00, 1'b0, 4'd2, 3'd0, 4'b0001, 1'b0},
    {S_ACT, 2'b10, 1'b0, 4'd2, 3'd0, 4'b0011, 1'b0},
    {S_ACT, 2'b10, 1'b0, 4'd2, 3'd5, 4'b0011, 1'b0},
    {S_RD,  2'b01, 1'b0, 4'd3, 3'd4, 4'b0011, 1'b0},
    {S_WR,  2'b00, 1'b0, 4'd4, 3'd0, 4'b0011, 1'b0},
    {S_MRS, 2'b00, 1'b0, 4'd9, 3'd1, 4'b0011, 1'b0},
    {S_PRE, 2'b10, 1'b0, 4'd5, 3'd0, 4'b0001, 1'b0},
    {S_ACT, 2'b01, 1'b0, 4'd2, 3'd0, 4'b0101, 1'b0},
    {S_PRE, 2'b10, 1'b1, 4'd5, 3'd0, 4'b0000, 1'b0},
    {S_REF, 2'b00, 1'b0, 4'd7, 3'd0, 4'b0000, 1'b0},
    {S_ACT, 2'b11, 1'b0, 4'd2, 3'd0, 4'b1000, 1'b0},
    {S_ACT, 2'b00, 1'b0, 4'd2, 3'd0, 4'b1001, 1'b0},
    {S_RD,  2'b00, 1'b1, 4'd3, 3'd0, 4'b1001, 1'b1},
    {S_WR,  2'b11, 1'b0, 4'd4, 3'd3, 4'b1001, 1'b1},
    {S_NOP, 2'b00, 1'b0, 4'd1, 3'd0, 4'b1000, 1'b0},
    {S_RD,  2'b11, 1'b0, 4'd3, 3'd0, 4'b1000, 1'b0},
    {S_ACT, 2'b00, 1'b0, 4'd2, 3'd6, 4'b1000, 1'b0},
    {S_NOP, 2'b00, 1'b0, 4'd1, 3'd0, 4'b1000, 1'b0},
    {S_ACT, 2'b00, 1'b0, 4'd2, 3'd0, 4'b1001, 1'b0},
    {S_WR,  2'b11, 1'b1, 4'd4, 3'd0, 4'b1001, 1'b1},
    {S_BST, 2'b00, 1'b0, 4'd6, 3'd0, 4'b0001, 1'b0},
    {S_RD,  2'b00, 1'b0, 4'd3, 3'd0, 4'b0001, 1'b0},
    {S_ACT, 2'b11, 1'b0, 4'd2, 3'd6, 4'b0001, 1'b0},
    {S_BST, 2'b00, 1'b0, 4'd6, 3'd0, 4'b0001, 1'b0},
    {S_REF, 2'b00, 1'b0, 4'd7, 3'd1, 4'b0001, 1'b0},
    {S_PRE, 2'b00, 1'b1, 4'd5, 3'd0, 4'b0000, 1'b0},
    {S_MRS, 2'b00, 1'b0, 4'd9, 3'd0, 4'b0000, 1'b0},
    {S_NOP, 2'b00, 1'b0, 4'd1, 3'd0, 4'b0000, 1'b0},
    {S_DES, 2'b00, 1'b0, 4'd0, 3'd0, 4'b0000, 1'b0},
    {S_ACT, 2'b10, 1'b0, 4'd2, 3'd0, 4'b0010, 1'b0}
  };

  function automatic string tag_of(input logic [3:0] c, input logic [2:0] e);
    case (e)
      3'd1: return "R9";
      3'd2: return "R10";
      3'd3: return "R6";
      3'd4: return "R5";
      3'd5: return "R3";
      3'd6: return "R8";
      default: case (c)
        4'd2: return "R3";
        4'd5: return "R4";
        4'd6: return "R7";
        4'd3, 4'd4: return "R6";
        default: return "R1";
      endcase
    endcase
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic drive(input logic [3:0] s, input logic [1:0] b, input logic ap,
                       input logic ck);
    {cs_n, ras_n, cas_n, we_n} = s;
    ba = b; a10 = ap; cke = ck;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] ec, input logic [2:0] ee,
                       input logic [3:0] eo, input logic eb);
    n_chk++;
    if (cmd_o !== ec || viol_code_o !== ee || viol_o !== (ee != 3'd0) ||
        bank_open_o !== eo || ap_busy_o !== eb) begin
      n_fail++;
      $display("FAIL %s: actual cmd=%0d code=%0d viol=%b open=%b busy=%b expected cmd=%0d code=%0d viol=%b open=%b busy=%b",
               req, cmd_o, viol_code_o, viol_o, bank_open_o, ap_busy_o,
               ec, ee, (ee != 3'd0), eo, eb);
    end
  endtask

  task automatic check_bank(input logic [1:0] eb);
    n_chk++;
    if (bank_o !== eb) begin
      n_fail++;
      $display("FAIL R2: actual bank=%0d expected bank=%0d", bank_o, eb);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R13: watchdog expired, actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: outputs held at reset values
    check("R13", 4'd0, 3'd0, 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      drive(v[18:15], v[14:13], v[12], 1'b1);
      check(tag_of(v[11:8], v[7:5]), v[11:8], v[7:5], v[4:1], v[0]);
    end

    // R12: self-refresh entry with bank 1 still open is rejected (code 1)
    drive(S_REF, 2'b00, 1'b0, 1'b0);
    check("R12", 4'd8, 3'd1, 4'b0010, 1'b0);
    // R12: previous cke low, activate ignored
    drive(S_ACT, 2'b00, 1'b0, 1'b1);
    check("R12", 4'd1, 3'd0, 4'b0010, 1'b0);
    drive(S_PRE, 2'b00, 1'b1, 1'b1);
    check("R4", 4'd5, 3'd0, 4'b0000, 1'b0);
    drive(S_REF, 2'b00, 1'b0, 1'b0);
    check("R12", 4'd8, 3'd0, 4'b0000, 1'b0);
    drive(S_ACT, 2'b00, 1'b0, 1'b0);
    check("R12", 4'd1, 3'd0, 4'b0000, 1'b0);
    drive(S_ACT, 2'b00, 1'b0, 1'b1);
    check("R12", 4'd1, 3'd0, 4'b0000, 1'b0);
    drive(S_ACT, 2'b00, 1'b0, 1'b1);
    check("R12", 4'd2, 3'd0, 4'b0001, 1'b0);

    // R2: bit-reversed bank mapping
    drive(S_PRE, 2'b10, 1'b0, 1'b1);
    check_bank(2'd1);
    drive(S_PRE, 2'b01, 1'b0, 1'b1);
    check_bank(2'd2);
    drive(S_PRE, 2'b11, 1'b0, 1'b1);
    check_bank(2'd3);
    check("R4", 4'd5, 3'd0, 4'b0001, 1'b0);
    drive(S_PRE, 2'b00, 1'b0, 1'b1);
    check_bank(2'd0);
    check("R4", 4'd5, 3'd0, 4'b0000, 1'b0);

    // R11: single-cycle pulse, illegal command leaves state alone
    drive(S_ACT, 2'b00, 1'b0, 1'b1);
    check("R3", 4'd2, 3'd0, 4'b0001, 1'b0);
    drive(S_RD, 2'b10, 1'b1, 1'b1);
    check("R11", 4'd3, 3'd4, 4'b0001, 1'b0);
    drive(S_NOP, 2'b00, 1'b0, 1'b1);
    check("R11", 4'd1, 3'd0, 4'b0001, 1'b0);

    // R13: reset in the middle of activity
    rst_n = 1'b0;
    #1;
    check("R13", 4'd0, 3'd0, 4'b0000, 1'b0);
    @(negedge clk);
    check("R13", 4'd0, 3'd0, 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    report();
    $finish;
  end
endmodule